// File: doc/BRIEF.md
# Single-Address DMA Channel

One channel of a DMA engine that moves data in single-address form. Each data unit crosses the external bus in one bus cycle. The channel drives one memory address and one memory strobe. The peripheral at the other end is selected by an active-low acknowledge line instead of a second address, so it drives or takes the data bus directly. Because only one side is addressed, memory-to-memory moves cannot be made with this channel.

Software arms the channel with a pulse on `arm`. The pulse loads a start address, a unit count, a block size and the mode settings. A transfer burst then starts from a software trigger pulse or from a hardware request. The trigger mode decides how many units one trigger moves: one unit, all remaining units, or one block. After each unit the address stays fixed or moves by the unit size. In successive and block modes the address can optionally snap back to its start. An active-low end pulse marks the last access of every burst. A completion flag rises when the unit count is used up.

Top module: `sadma_channel`

## Requirements
- R1: Out of reset no bus cycle runs: `ack_n`, `bus_rd_n`, `bus_wr_n` and `end_n` are high and `irq` is low.
- R2: A pulse on `arm` while no burst runs loads address, count, block size and settings, and clears `irq` and any pending trigger. The channel becomes enabled only if the count is nonzero. Triggers seen while the channel is not enabled, including the arm cycle itself, have no effect.
- R3: With `cfg_mode` = 0 (single), each trigger moves exactly one unit.
- R4: With `cfg_mode` = 1 (successive), one trigger moves every remaining unit in consecutive bus cycles.
- R5: With `cfg_mode` = 2 (block), one trigger moves min(`cfg_blk`, remaining) units in consecutive cycles.
- R6: After each unit the address moves by the unit size: 1, 2 or 4 bytes for `cfg_size` = 0, 1 or 2. `cfg_step` = 1 increments, 2 decrements, and 0 or 3 holds the address. Arithmetic wraps modulo 2^AW.
- R7: With `cfg_reload` = 1 in successive or block mode, the address after the last unit of each burst returns to the armed start address. Single mode never reloads.
- R8: `ack_n` is low in every transfer cycle and only then. In that cycle `bus_rd_n` is low when `cfg_dir` = 1 (memory to peripheral), or `bus_wr_n` is low when `cfg_dir` = 0 (peripheral to memory). The other strobe stays high.
- R9: `end_n` is low only in the final transfer cycle of each burst, and the cycle after it is idle.
- R10: A burst begins in the cycle after an enabled idle cycle in which `sw_trig` or `hw_req` is high or a trigger is pending. Triggers arriving during a burst collapse into a single pending trigger.
- R11: When the remaining count reaches zero, `irq` rises in the cycle after the last unit and the channel disables itself. Later triggers are ignored until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Load settings and enable the channel |
| sw_trig | input | 1 | Software trigger pulse |
| hw_req | input | 1 | Hardware request |
| cfg_dir | input | 1 | 1: memory to peripheral (read), 0: peripheral to memory (write) |
| cfg_size | input | 2 | Unit size code: 0 byte, 1 half, 2 word |
| cfg_mode | input | 2 | 0 single, 1 successive, 2 block |
| cfg_step | input | 2 | 0 hold, 1 increment, 2 decrement |
| cfg_reload | input | 1 | Restore start address at the end of each burst |
| cfg_addr | input | AW | Start address |
| cfg_count | input | CW | Total units to move |
| cfg_blk | input | BW | Units per block |
| bus_addr | output | AW | Memory address |
| bus_rd_n | output | 1 | Memory read strobe, active low |
| bus_wr_n | output | 1 | Memory write strobe, active low |
| ack_n | output | 1 | Peripheral acknowledge, active low |
| end_n | output | 1 | Last access of a burst, active low |
| irq | output | 1 | Count exhausted flag |

## Verification
The bench builds the channel with a 12-bit address, a 6-bit count and a 3-bit block size. With a 12-bit address, a decrement from a low start address wraps past zero inside a few cycles. The small count and block widths let a run end with a partial final block, and let completion be reached quickly in every mode. A behavioural model predicts every output on every clock, so the cycle each burst starts and the placement of the end pulse are checked exactly.

// File: rtl/sadma_pkg.sv
// Shared encodings for the single-address DMA channel.
package sadma_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_SUCC   = 2'd1,
        MODE_BLOCK  = 2'd2,
        MODE_RSVD   = 2'd3
    } xmode_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_RSVD = 2'd3
    } step_e;
endpackage

// File: rtl/sadma_trig.sv
// Trigger front end. Combines the software and hardware triggers and holds
// a one-deep pending flag for triggers seen during a burst.
// Assumes: the start output is consumed in the same cycle it is raised.
module sadma_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm_any,
    input  logic en,
    input  logic active,
    input  logic sw_trig,
    input  logic hw_req,
    output logic start,
    output logic pend
);
    logic trig;

    // Any trigger source this cycle.
    assign trig  = sw_trig | hw_req;
    // Start a burst from an enabled idle cycle.
    assign start = en & ~active & ~arm_any & (trig | pend);

    // Pending flag: set by a trigger during a burst, cleared on start or arm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || start) begin
            pend <= 1'b0;
        end else if (en && active && trig) begin
            pend <= 1'b1;
        end
    end

    assert_pend_consumed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !pend);
endmodule

// File: rtl/sadma_count.sv
// Unit counters. Tracks units left overall and units left in the current
// burst, and sizes each burst from the trigger mode.
// Assumes: CW >= BW; start only arrives while remaining is nonzero.
module sadma_count
    import sadma_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_cnt,
    input  logic          start,
    input  xmode_e        mode,
    input  logic [BW-1:0] blk,
    input  logic          advance,
    output logic          last_unit,
    output logic          final_unit
);
    localparam int PAD = CW - BW;

    logic [CW-1:0] rem;
    logic [CW-1:0] left;
    logic [CW-1:0] blk_w;
    logic [CW-1:0] burst_len;

    assign blk_w = {{PAD{1'b0}}, blk};

    // Burst length chosen by the trigger mode.
    always_comb begin
        case (mode)
            MODE_SUCC:  burst_len = rem;
            MODE_BLOCK: burst_len = (blk_w < rem) ? blk_w : rem;
            default:    burst_len = {{(CW-1){1'b0}}, 1'b1};
        endcase
    end

    // Load, size and count down the two counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            left <= '0;
        end else if (load) begin
            rem  <= load_cnt;
            left <= '0;
        end else if (start) begin
            left <= burst_len;
        end else if (advance) begin
            rem  <= rem - 1'b1;
            left <= left - 1'b1;
        end
    end

    assign last_unit  = (left == {{(CW-1){1'b0}}, 1'b1});
    assign final_unit = (rem  == {{(CW-1){1'b0}}, 1'b1});

    assert_burst_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (left != '0) && (left <= $past(rem)));
endmodule

// File: rtl/sadma_addr.sv
// Address generator. Holds the current and start addresses, steps by the
// unit size after each unit and restores the start address on request.
// Assumes: restore is only raised together with advance.
module sadma_addr
    import sadma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          advance,
    input  logic          restore,
    input  unit_e         size,
    input  step_e         step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] init;
    logic [AW-1:0] bytes;
    logic [AW-1:0] next;

    // Byte step for the unit size.
    always_comb begin
        case (size)
            SZ_BYTE: bytes = AW'(1);
            SZ_HALF: bytes = AW'(2);
            default: bytes = AW'(4);
        endcase
    end

    // Next address for the step direction.
    always_comb begin
        case (step)
            STEP_INC: next = addr + bytes;
            STEP_DEC: next = addr - bytes;
            default:  next = addr;
        endcase
    end

    // Address and start address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            init <= '0;
        end else if (load) begin
            addr <= load_addr;
            init <= load_addr;
        end else if (advance) begin
            addr <= restore ? init : next;
        end
    end

    assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !restore && (step == STEP_HOLD || step == STEP_RSVD) |=> $stable(addr));
    assert_restore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        advance && restore && !load |=> addr == init);
endmodule

// File: rtl/sadma_channel.sv
// Single-address DMA channel top. Captures settings on arm, runs bursts on
// triggers, and drives the memory strobes with the peripheral acknowledge.
// Assumes: arm is not raised during a burst (it is ignored then).
module sadma_channel
    import sadma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          sw_trig,
    input  logic          hw_req,
    input  logic          cfg_dir,
    input  logic [1:0]    cfg_size,
    input  logic [1:0]    cfg_mode,
    input  logic [1:0]    cfg_step,
    input  logic          cfg_reload,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic [BW-1:0] cfg_blk,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic          ack_n,
    output logic          end_n,
    output logic          irq
);
    logic          en, active, irq_q;
    logic          dir_q, reload_q;
    unit_e         size_q;
    xmode_e        mode_q;
    step_e         step_q;
    logic [BW-1:0] blk_q;
    logic          arm_ok, start, pend, last_unit, final_unit, restore;

    assign arm_ok  = arm & ~active;
    assign restore = active & last_unit & reload_q & (mode_q != MODE_SINGLE);

    // Channel state and captured settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            active   <= 1'b0;
            irq_q    <= 1'b0;
            dir_q    <= 1'b0;
            reload_q <= 1'b0;
            size_q   <= SZ_BYTE;
            mode_q   <= MODE_SINGLE;
            step_q   <= STEP_HOLD;
            blk_q    <= '0;
        end else if (arm_ok) begin
            en       <= (cfg_count != '0);
            irq_q    <= 1'b0;
            dir_q    <= cfg_dir;
            reload_q <= cfg_reload;
            size_q   <= unit_e'(cfg_size);
            mode_q   <= xmode_e'(cfg_mode);
            step_q   <= step_e'(cfg_step);
            blk_q    <= cfg_blk;
        end else if (start) begin
            active <= 1'b1;
        end else if (active && last_unit) begin
            active <= 1'b0;
            if (final_unit) begin
                en    <= 1'b0;
                irq_q <= 1'b1;
            end
        end
    end

    sadma_trig u_trig (
        .clk(clk), .rst_n(rst_n), .clr(arm_ok), .arm_any(arm), .en(en),
        .active(active), .sw_trig(sw_trig), .hw_req(hw_req),
        .start(start), .pend(pend)
    );

    sadma_count #(.CW(CW), .BW(BW)) u_count (
        .clk(clk), .rst_n(rst_n), .load(arm_ok), .load_cnt(cfg_count),
        .start(start), .mode(mode_q), .blk(blk_q), .advance(active),
        .last_unit(last_unit), .final_unit(final_unit)
    );

    sadma_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(arm_ok), .load_addr(cfg_addr),
        .advance(active), .restore(restore), .size(size_q), .step(step_q),
        .addr(bus_addr)
    );

    // Bus-side outputs decoded from the burst state.
    assign ack_n    = ~active;
    assign bus_rd_n = ~(active & dir_q);
    assign bus_wr_n = ~(active & ~dir_q);
    assign end_n    = ~(active & last_unit);
    assign irq      = irq_q;

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (bus_rd_n != bus_wr_n));
    assert_end_in_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !end_n |-> !ack_n);
    assert_idle_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !end_n |=> ack_n);
    assert_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n && end_n |=> !ack_n);
    assert_irq_disables_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !en && ack_n);
endmodule

// File: tb/sadma_channel_test.sv
module sadma_channel_test;
    localparam int AW = 12;
    localparam int CW = 6;
    localparam int BW = 3;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0, sw_trig = 1'b0, hw_req = 1'b0;
    logic cfg_dir = 1'b0, cfg_reload = 1'b0;
    logic [1:0] cfg_size = '0, cfg_mode = '0, cfg_step = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [BW-1:0] cfg_blk = '0;
    logic [AW-1:0] bus_addr;
    logic bus_rd_n, bus_wr_n, ack_n, end_n, irq;

    int vectors = 0, fails = 0, cyc = 0, acks = 0;
    bit done = 0;

    // Behavioural model state.
    int m_en = 0, m_act = 0, m_pend = 0, m_irq = 0;
    int m_addr = 0, m_init = 0, m_rem = 0, m_left = 0;
    int m_dir = 0, m_size = 0, m_mode = 0, m_step = 0, m_reload = 0, m_blk = 0;

    always #2.5 clk = ~clk;

    sadma_channel #(.AW(AW), .CW(CW), .BW(BW)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sw_trig(sw_trig), .hw_req(hw_req),
        .cfg_dir(cfg_dir), .cfg_size(cfg_size), .cfg_mode(cfg_mode),
        .cfg_step(cfg_step), .cfg_reload(cfg_reload), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_blk(cfg_blk), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .ack_n(ack_n),
        .end_n(end_n), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int stepped(input int a);
        int b;
        b = (m_size == 0) ? 1 : (m_size == 1) ? 2 : 4;
        if (m_step == 1) return (a + b) & MASK;
        if (m_step == 2) return (a - b) & MASK;
        return a;
    endfunction

    // Reference model advanced on every rising edge.
    always @(posedge clk) begin
        int trig, en_before;
        cyc++;
        trig = sw_trig | hw_req;
        en_before = m_en;
        if (!rst_n) begin
            m_en = 0; m_act = 0; m_pend = 0; m_irq = 0; m_addr = 0; m_init = 0;
            m_rem = 0; m_left = 0; m_dir = 0; m_size = 0; m_mode = 0; m_step = 0;
            m_reload = 0; m_blk = 0;
        end else if (m_act) begin
            if (trig && en_before) m_pend = 1;
            m_rem--; m_left--;
            if (m_left == 0) begin
                m_act = 0;
                if (m_reload && (m_mode == 1 || m_mode == 2)) m_addr = m_init;
                else m_addr = stepped(m_addr);
                if (m_rem == 0) begin m_en = 0; m_irq = 1; end
            end else begin
                m_addr = stepped(m_addr);
            end
        end else if (arm) begin
            m_addr = cfg_addr; m_init = cfg_addr; m_rem = cfg_count; m_left = 0;
            m_en = (cfg_count != 0); m_irq = 0; m_pend = 0;
            m_dir = cfg_dir; m_size = cfg_size; m_mode = cfg_mode; m_step = cfg_step;
            m_reload = cfg_reload; m_blk = cfg_blk;
        end else if (m_en && (trig || m_pend)) begin
            m_act = 1; m_pend = 0;
            if (m_mode == 1) m_left = m_rem;
            else if (m_mode == 2) m_left = (m_blk < m_rem) ? m_blk : m_rem;
            else m_left = 1;
        end
    end

    // Compare every output against the model away from the edge.
    always @(negedge clk) begin
        if (!done) begin
            if (rst_n && !ack_n) acks++;
            chk(ack_n == !m_act, "R8 ack", ack_n, !m_act);
            chk(bus_rd_n == !(m_act && m_dir), "R8 rd strobe", bus_rd_n, !(m_act && m_dir));
            chk(bus_wr_n == !(m_act && !m_dir), "R8 wr strobe", bus_wr_n, !(m_act && !m_dir));
            chk(end_n == !(m_act && m_left == 1), "R9 end", end_n, !(m_act && m_left == 1));
            chk(irq == m_irq[0], "R11 irq", irq, m_irq);
            if (m_act) chk(int'(bus_addr) == m_addr, "R6/R7 addr", bus_addr, m_addr);
        end
    end

    task automatic pulse_sw();
        @(negedge clk); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    endtask
    task automatic pulse_hw();
        @(negedge clk); hw_req = 1'b1; @(negedge clk); hw_req = 1'b0;
    endtask
    task automatic do_arm(input int dir, input int sz, input int md, input int st,
                          input int rl, input int ad, input int cnt, input int bk);
        @(negedge clk);
        cfg_dir = dir[0]; cfg_size = sz[1:0]; cfg_mode = md[1:0]; cfg_step = st[1:0];
        cfg_reload = rl[0]; cfg_addr = ad[AW-1:0]; cfg_count = cnt[CW-1:0];
        cfg_blk = bk[BW-1:0]; arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failure.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            summary();
        end
    end

    initial begin
        idle(3);
        // R1: quiet bus during and right after reset.
        chk(ack_n && bus_rd_n && bus_wr_n && end_n && !irq, "R1 reset", {ack_n, end_n, irq}, 3'b110);
        rst_n = 1'b1;
        idle(2);

        // R2: triggers before any arm do nothing.
        acks = 0;
        pulse_sw(); pulse_hw(); idle(4);
        chk(acks == 0, "R2 unarmed trigger", acks, 0);

        // R2: arm with zero count stays disabled.
        do_arm(1, 2, 1, 1, 0, 'h10, 0, 0);
        acks = 0; pulse_hw(); idle(4);
        chk(acks == 0, "R2 zero count", acks, 0);

        // R3/R11: single mode, word steps, three triggers then done.
        do_arm(1, 2, 0, 1, 1, 'h100, 3, 0);
        acks = 0;
        pulse_sw(); idle(3);
        chk(acks == 1, "R3 one unit", acks, 1);
        pulse_hw(); idle(3); pulse_sw(); idle(3);
        chk(acks == 3, "R3 three units", acks, 3);
        chk(irq == 1'b1, "R11 done flag", irq, 1);
        pulse_sw(); idle(4);
        chk(acks == 3, "R11 trigger after done", acks, 3);

        // R4/R6: successive, half-word decrement wrapping past zero, writes.
        do_arm(0, 1, 1, 2, 0, 'h002, 4, 0);
        chk(irq == 1'b0, "R2 arm clears flag", irq, 0);
        acks = 0; pulse_hw(); idle(8);
        chk(acks == 4, "R4 all units", acks, 4);

        // R7/R4: successive byte increment with reload, trigger mid-burst.
        do_arm(1, 0, 1, 1, 1, 'h7FE, 5, 0);
        acks = 0;
        @(negedge clk); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
        idle(1); pulse_hw(); idle(8);
        chk(acks == 5, "R10 no extra burst after done", acks, 5);

        // R5/R10/R7: block of 3 from 7, pending trigger, partial last block.
        do_arm(1, 1, 2, 1, 1, 'h040, 7, 3);
        acks = 0;
        pulse_hw(); pulse_sw(); idle(10);
        chk(acks == 6, "R10 pending starts second block", acks, 6);
        pulse_sw(); idle(4);
        chk(acks == 7, "R5 partial block", acks, 7);
        chk(irq == 1'b1, "R11 block done", irq, 1);

        // R6: hold address, word size, block mode without reload.
        do_arm(0, 2, 2, 0, 0, 'h333, 4, 2);
        acks = 0; pulse_sw(); idle(4); pulse_sw(); idle(4);
        chk(acks == 4, "R6 hold bursts", acks, 4);

        summary();
    end
endmodule